// File: doc/BRIEF.md
# Dual-Controller Address Section Mapper

This block turns the installed memory sizes behind two memory controllers (A and B) into an address-map description of up to four 32-bit section descriptors. When both controllers hold memory, the block first builds one interleaved section. That section takes the same amount from each controller, and that amount is the smaller of the two sizes. Whatever memory is left over belongs to a single controller. It gets its own section, placed in system address space just after the interleaved region. Descriptor slot 0 is always a fixed trap word that catches accesses to unmapped space.

Software or a boot sequencer drives both sizes and pulses `start_i` for one cycle. One cycle later `done_o` pulses, and the descriptor words and the error flag hold the result. The block has no back-pressure: each start pulse is taken, and the outputs stay stable until the next start that changes them. The system base address of the map is a parameter.

Top module: `mc_section_mapper`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0, slots 3, 2 and 1 are zero, and slot 0 holds `TRAP_WORD` (default 32'hFF00_0080).
- R2: `done_o` is high in exactly the cycle that follows a cycle with `start_i` high, and low otherwise. The results are valid while `done_o` is high.
- R3: Descriptor layout: bits 31:24 hold the system base MSBs, bits 23:16 the controller-local base MSBs, bits 10:8 the size code, and bits 1:0 the target (0 none, 1 controller A, 2 controller B, 3 both interleaved). All other bits are zero.
- R4: Sizes count in 16 MiB units taken from size bits 31:24; bits 23:0 are ignored once the size is at least 16 MiB. The size code is floor(log2(units)), so code 0 means 16 MiB and code 7 means 2 GiB.
- R5: When both sizes are nonzero, slot 3 holds the interleaved section. Its system MSBs are `SYS_BASE[31:24]` (default 8'h80), its local base is 0, its target is 3, and its size code is that of twice the smaller unit count.
- R6: A leftover on one controller goes to slot 2. Its system MSBs are `SYS_BASE[31:24]` plus twice the smaller unit count, its local MSBs equal the smaller unit count, its target is the owning controller, and its size code is that of the leftover.
- R7: When only one section exists, it is written to slot 3 and slot 2 is zero. A section on one controller only has system MSBs `SYS_BASE[31:24]` and local base 0.
- R8: Slot 1 is always zero and slot 0 always holds `TRAP_WORD`.
- R9: When both sizes are zero, a start leaves all slots unchanged and clears `err_o`.
- R10: A start sets `err_o` and leaves all slots unchanged when a size is nonzero but below 16 MiB, or when the interleaved total reaches 256 units (4 GiB).
- R11: `err_o` holds until the next start, and a start without an error condition clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to compute the map |
| size_a_i | input | 32 | Memory size behind controller A, in bytes |
| size_b_i | input | 32 | Memory size behind controller B, in bytes |
| done_o | output | 1 | Pulses one cycle after a start |
| err_o | output | 1 | Result of the last start was rejected |
| slot0_o | output | 32 | Trap descriptor |
| slot1_o | output | 32 | Unused descriptor, always zero |
| slot2_o | output | 32 | Second section descriptor |
| slot3_o | output | 32 | First section descriptor |

## Verification
The whole computation runs between one clock edge and the next, so a wrong minimum, owner or encoder result shows up in slot 3 or slot 2 in the same cycle that `done_o` rises. The slots keep their value between starts. A load that should have been suppressed, whether because both sizes are zero or because of an error, is therefore visible as a changed descriptor at the very next `done_o`. A stale or sticky error flag shows on `err_o` at the first clean start that follows.

// File: rtl/secmap_pkg.sv
package secmap_pkg;
  localparam int WORD_W   = 32;
  localparam int UNIT_LSB = 24;
  localparam int UNIT_W   = WORD_W - UNIT_LSB;
  localparam int CODE_W   = $clog2(UNIT_W);

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_CTRL_A = 2'd1,
    TGT_CTRL_B = 2'd2,
    TGT_BOTH   = 2'd3
  } target_e;

  typedef struct packed {
    logic [UNIT_W-1:0] sys_msb;
    logic [UNIT_W-1:0] loc_msb;
    logic [4:0]        pad_hi;
    logic [CODE_W-1:0] size_code;
    logic [5:0]        pad_lo;
    target_e           target;
  } desc_t;

  function automatic desc_t make_desc(input logic [UNIT_W-1:0] sys_msb,
                                      input logic [UNIT_W-1:0] loc_msb,
                                      input logic [CODE_W-1:0] code,
                                      input target_e           tgt);
    desc_t d;
    d           = '0;
    d.sys_msb   = sys_msb;
    d.loc_msb   = loc_msb;
    d.size_code = code;
    d.target    = tgt;
    return d;
  endfunction
endpackage

// File: rtl/secmap_log2.sv
// Priority encoder: index of the highest set bit (floor log2).
module secmap_log2 #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     val,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/secmap_plan.sv
// Combinational section planner working in 16 MiB units.
module secmap_plan
  import secmap_pkg::*;
#(
  parameter logic [UNIT_W-1:0] BASE_MSB = 8'h80
) (
  input  logic [UNIT_W-1:0] units_a,
  input  logic [UNIT_W-1:0] units_b,
  output desc_t             first_sec,
  output desc_t             second_sec,
  output logic              no_mem,
  output logic              too_big
);
  localparam int IL_W       = UNIT_W + 1;
  localparam int IL_IDX_W   = $clog2(IL_W);
  localparam int LEFT_IDX_W = $clog2(UNIT_W);

  logic                  has_a, has_b, both, has_left;
  logic [UNIT_W-1:0]     min_u, left_u, sec_base;
  logic [IL_W-1:0]       il_u;
  logic [IL_IDX_W-1:0]   il_idx;
  logic [LEFT_IDX_W-1:0] left_idx;
  target_e               owner;
  desc_t                 il_desc, single_desc;

  always_comb begin
    has_a    = |units_a;
    has_b    = |units_b;
    both     = has_a && has_b;
    no_mem   = !has_a && !has_b;
    min_u    = (units_a < units_b) ? units_a : units_b;
    il_u     = IL_W'(min_u) << 1;
    left_u   = (units_a - min_u) | (units_b - min_u);
    has_left = |left_u;
    owner    = (units_a > min_u) ? TGT_CTRL_A : TGT_CTRL_B;
    sec_base = both ? UNIT_W'(BASE_MSB + il_u[UNIT_W-1:0]) : BASE_MSB;
  end

  secmap_log2 #(.W(IL_W))   i_il_enc   (.val(il_u),   .idx(il_idx));
  secmap_log2 #(.W(UNIT_W)) i_left_enc (.val(left_u), .idx(left_idx));

  always_comb begin
    too_big     = both && (il_idx >= IL_IDX_W'(UNIT_W));
    il_desc     = make_desc(BASE_MSB, '0, il_idx[CODE_W-1:0], TGT_BOTH);
    single_desc = make_desc(sec_base, min_u, CODE_W'(left_idx), owner);
    first_sec   = both ? il_desc : single_desc;
    second_sec  = (both && has_left) ? single_desc : '0;
  end
endmodule

// File: rtl/secmap_store.sv
// Descriptor registers, done pulse and error flag.
module secmap_store
  import secmap_pkg::*;
#(
  parameter logic [WORD_W-1:0] TRAP_WORD = 32'hFF00_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              load,
  input  logic              err_in,
  input  desc_t             hi_desc,
  input  desc_t             lo_desc,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] slot0,
  output logic [WORD_W-1:0] slot1,
  output logic [WORD_W-1:0] slot2,
  output logic [WORD_W-1:0] slot3
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err   <= 1'b0;
      slot0 <= TRAP_WORD;
      slot1 <= '0;
      slot2 <= '0;
      slot3 <= '0;
    end else begin
      done <= start;
      if (start) err <= err_in;
      if (load) begin
        slot3 <= hi_desc;
        slot2 <= lo_desc;
        slot1 <= '0;
        slot0 <= TRAP_WORD;
      end
    end
  end
endmodule

// File: rtl/mc_section_mapper.sv
module mc_section_mapper
  import secmap_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYS_BASE  = 32'h8000_0000,
  parameter logic [WORD_W-1:0] TRAP_WORD = 32'hFF00_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] size_a_i,
  input  logic [WORD_W-1:0] size_b_i,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] slot0_o,
  output logic [WORD_W-1:0] slot1_o,
  output logic [WORD_W-1:0] slot2_o,
  output logic [WORD_W-1:0] slot3_o
);
  localparam logic [UNIT_W-1:0] BASE_MSB = SYS_BASE[WORD_W-1:UNIT_LSB];

  logic [UNIT_W-1:0] units_a, units_b;
  logic              tiny_a, tiny_b, no_mem, too_big, err_next, load;
  desc_t             first_sec, second_sec;

  always_comb begin
    units_a  = size_a_i[WORD_W-1:UNIT_LSB];
    units_b  = size_b_i[WORD_W-1:UNIT_LSB];
    tiny_a   = (units_a == '0) && (|size_a_i[UNIT_LSB-1:0]);
    tiny_b   = (units_b == '0) && (|size_b_i[UNIT_LSB-1:0]);
    err_next = tiny_a || tiny_b || too_big;
    load     = start_i && !err_next && !no_mem;
  end

  secmap_plan #(.BASE_MSB(BASE_MSB)) i_plan (
    .units_a    (units_a),
    .units_b    (units_b),
    .first_sec  (first_sec),
    .second_sec (second_sec),
    .no_mem     (no_mem),
    .too_big    (too_big)
  );

  secmap_store #(.TRAP_WORD(TRAP_WORD)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .load    (load),
    .err_in  (err_next),
    .hi_desc (first_sec),
    .lo_desc (second_sec),
    .done    (done_o),
    .err     (err_o),
    .slot0   (slot0_o),
    .slot1   (slot1_o),
    .slot2   (slot2_o),
    .slot3   (slot3_o)
  );
endmodule

// File: rtl/secmap_checker.sv
module secmap_checker #(
  parameter logic [31:0] SYS_BASE  = 32'h8000_0000,
  parameter logic [31:0] TRAP_WORD = 32'hFF00_0080
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] size_a_i,
  input logic [31:0] size_b_i,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] slot0_o,
  input logic [31:0] slot1_o,
  input logic [31:0] slot2_o,
  input logic [31:0] slot3_o
);
  AST_TRAP_FIXED: assert property (@(posedge clk) disable iff (!rst_n) slot0_o == TRAP_WORD); // R8
  AST_SLOT1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) slot1_o == 32'h0); // R8
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> done_o); // R2
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(start_i)); // R2
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(size_a_i == 32'h0 && size_b_i == 32'h0)) |-> ($stable(slot3_o) && $stable(slot2_o))); // R9
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> ($stable(slot3_o) && $stable(slot2_o))); // R10
  AST_IL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && $past(size_a_i[31:24] != 8'h0 && size_b_i[31:24] != 8'h0))
    |-> (slot3_o[1:0] == 2'b11 && slot3_o[23:16] == 8'h0 && slot3_o[31:24] == SYS_BASE[31:24])); // R5
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot3_o[15:11] == 5'h0 && slot3_o[7:2] == 6'h0 && slot2_o[15:11] == 5'h0 && slot2_o[7:2] == 6'h0)); // R3
endmodule

bind mc_section_mapper secmap_checker #(.SYS_BASE(SYS_BASE), .TRAP_WORD(TRAP_WORD)) i_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .size_a_i (size_a_i),
  .size_b_i (size_b_i),
  .done_o   (done_o),
  .err_o    (err_o),
  .slot0_o  (slot0_o),
  .slot1_o  (slot1_o),
  .slot2_o  (slot2_o),
  .slot3_o  (slot3_o)
);

// File: tb/test_mc_section_mapper.sv
module test_mc_section_mapper;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TRAP = 32'hFF00_0080;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] s3;
    logic [31:0] s2;
  } vec_t;

  // size A, size B, expected slot 3, expected slot 2 (base MSB 8'h80)
  localparam vec_t VEC [9] = '{
    '{32'h1000_0000, 32'h1000_0000, 32'h8000_0503, 32'h0000_0000},
    '{32'h2000_0000, 32'h1000_0000, 32'h8000_0503, 32'hA010_0401},
    '{32'h0800_0000, 32'h4000_0000, 32'h8000_0403, 32'h9008_0502},
    '{32'h4000_0000, 32'h0000_0000, 32'h8000_0601, 32'h0000_0000},
    '{32'h0000_0000, 32'h0100_0000, 32'h8000_0002, 32'h0000_0000},
    '{32'h8000_0000, 32'h0000_0000, 32'h8000_0701, 32'h0000_0000},
    '{32'h0300_0000, 32'h0300_0000, 32'h8000_0203, 32'h0000_0000},
    '{32'h0600_0000, 32'h0200_0000, 32'h8000_0203, 32'h8402_0201},
    '{32'h05FF_FFFF, 32'h0000_0000, 32'h8000_0201, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] size_a_i = '0;
  logic [31:0] size_b_i = '0;
  logic        done_o, err_o;
  logic [31:0] slot0_o, slot1_o, slot2_o, slot3_o;
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_section_mapper i_mc_section_mapper (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .size_a_i(size_a_i), .size_b_i(size_b_i),
    .done_o(done_o), .err_o(err_o),
    .slot0_o(slot0_o), .slot1_o(slot1_o), .slot2_o(slot2_o), .slot3_o(slot3_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one start pulse; leaves the bench at the negedge where done is high.
  task automatic run(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    size_a_i = a;
    size_b_i = b;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done", {31'b0, done_o}, 32'h1 & 32'h0);
    check("R1 err", {31'b0, err_o}, 32'h0);
    check("R1 slot3", slot3_o, 32'h0);
    check("R1 slot2", slot2_o, 32'h0);
    check("R1 slot1", slot1_o, 32'h0);
    check("R1 slot0", slot0_o, TRAP);

    foreach (VEC[i]) begin
      run(VEC[i].a, VEC[i].b);
      check("R2 done high", {31'b0, done_o}, 32'h1);
      check("R3 R4 R5 R7 slot3", slot3_o, VEC[i].s3);
      check("R3 R6 R7 slot2", slot2_o, VEC[i].s2);
      check("R8 slot1", slot1_o, 32'h0);
      check("R8 slot0", slot0_o, TRAP);
      check("R10 err low", {31'b0, err_o}, 32'h0);
      @(negedge clk);
      check("R2 done one cycle", {31'b0, done_o}, 32'h0);
    end

    // R9: both zero leaves map untouched
    run(32'h0, 32'h0);
    check("R9 done", {31'b0, done_o}, 32'h1);
    check("R9 slot3 kept", slot3_o, 32'h8000_0201);
    check("R9 slot2 kept", slot2_o, 32'h0);
    check("R9 err", {31'b0, err_o}, 32'h0);

    // R10: size below 16 MiB
    run(32'h0080_0000, 32'h1000_0000);
    check("R10 tiny err", {31'b0, err_o}, 32'h1);
    check("R10 tiny slot3 kept", slot3_o, 32'h8000_0201);
    check("R10 tiny slot2 kept", slot2_o, 32'h0);
    @(negedge clk);
    check("R11 err held", {31'b0, err_o}, 32'h1);

    // R11: clean start clears error
    run(32'h2000_0000, 32'h1000_0000);
    check("R11 err cleared", {31'b0, err_o}, 32'h0);
    check("R11 slot3", slot3_o, 32'h8000_0503);
    check("R11 slot2", slot2_o, 32'hA010_0401);

    // R10: interleaved total reaches 4 GiB
    run(32'h8000_0000, 32'h8000_0000);
    check("R10 ovf err", {31'b0, err_o}, 32'h1);
    check("R10 ovf slot3 kept", slot3_o, 32'h8000_0503);
    check("R10 ovf slot2 kept", slot2_o, 32'hA010_0401);

    // R9 after error: clears err, keeps map
    run(32'h0, 32'h0);
    check("R9 err cleared", {31'b0, err_o}, 32'h0);
    check("R9 slot2 kept again", slot2_o, 32'hA010_0401);

    // R1: reset in the middle restores reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 slot3 after reset", slot3_o, 32'h0);
    check("R1 slot2 after reset", slot2_o, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule